// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches page translations. Each of its entries pairs a virtual page number with a physical frame number, a two-bit permission code and a pin flag. A lookup compares the requested page number against every entry at once. In the same cycle it reports a hit or a miss, the frame number and whether the requested kind of access is allowed. When the page walker outside the block has fetched a missing translation, it presents the translation on the fill port and the block installs it.

A fill whose page number is already cached rewrites that entry in place. Otherwise the fill takes a free slot if one exists. When every slot is in use, it evicts an unpinned entry, chosen either pseudo-randomly or as the least recently used, as a mode input selects. A flush pulse, issued on a context switch, drops every unpinned translation in one cycle. Pinned translations stay resident until they are overwritten or the block is reset.

Top module: `vxt_tlb`

## Requirements
- R1: After synchronous reset no entry is valid: every lookup misses, with frame output 0 and fault low.
- R2: With `lk_req` high, `lk_hit` or `lk_miss` rises in the same cycle. On a hit `lk_pfn` carries the frame of the matching entry, and on a miss it is 0. With `lk_req` low, both `lk_hit` and `lk_miss` stay low.
- R3: Permission codes are 0 read-only, 1 read-write, 2 execute-only and 3 no access. Access codes are 0 read, 1 write, 2 instruction fetch and 3 reserved. `lk_fault` is high only on a hit whose access the code forbids. A reserved access always faults on a hit.
- R4: An accepted fill is visible to lookups from the next cycle, with the filled frame and permission.
- R5: A fill whose page number matches a valid entry rewrites that entry's frame, permission and pin flag, and evicts nothing.
- R6: While any slot is invalid, a fill with a new page number evicts no valid entry.
- R7: With `repl_lru` = 1 and no free slot, a fill evicts the unpinned valid entry whose last hit or fill lies furthest back.
- R8: With `repl_lru` = 0 and no free slot, a fill evicts exactly one unpinned entry and leaves every other entry unchanged.
- R9: A pinned entry is never chosen as a victim. If every entry is valid and pinned, a fill with a new page number is dropped and the table is unchanged.
- R10: A `flush` pulse invalidates every unpinned entry at the next edge, and pinned entries keep hitting.
- R11: When events coincide in one cycle: a fill issued together with a flush survives the flush. A lookup issued together with a fill sees the table as it was before the fill. When a fill is accepted, only the filled entry counts as used in that cycle, even if the lookup in the same cycle hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repl_lru | input | 1 | Victim policy: 1 least recently used, 0 pseudo-random |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 reserved) |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_miss | output | 1 | Lookup found no valid entry |
| lk_pfn | output | 20 | Translated frame number, 0 unless hit |
| lk_fault | output | 1 | Hit, but the access is not permitted |
| fl_req | input | 1 | Fill request |
| fl_vpn | input | 20 | Page number to install |
| fl_pfn | input | 20 | Frame number to install |
| fl_perm | input | 2 | Permission code to install |
| fl_wired | input | 1 | Pin the installed entry |
| flush | input | 1 | Invalidate all unpinned entries |

## Verification
A lookup and a fill can occur in the same cycle, and so can a fill and a flush. The bench provokes each pair on purpose. A lookup is issued for the very page being filled, and a lookup hit is placed in the same cycle as a fill so that the replacement order depends on which of the two counts as the use. A flush is pulsed in the cycle that installs a new translation. The behavioural model applies the rules of R11 to judge each case, and later lookups and evictions expose any difference between the model and the design.

// File: rtl/vxt_pkg.sv
package vxt_pkg;

    localparam int VPN_W = 20;
    localparam int PFN_W = 20;

    typedef enum logic [1:0] {
        PERM_RO   = 2'b00,
        PERM_RW   = 2'b01,
        PERM_XO   = 2'b10,
        PERM_NONE = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic             valid;
        logic             wired;
        perm_e            perm;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } entry_t;

    function automatic logic perm_allows(perm_e p, acc_e a);
        case (p)
            PERM_RO: return a == ACC_READ;
            PERM_RW: return (a == ACC_READ) || (a == ACC_WRITE);
            PERM_XO: return a == ACC_FETCH;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vxt_cam.sv
module vxt_cam
    import vxt_pkg::*;
#(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]            valid_v,
    input  logic [N-1:0][VPN_W-1:0] vpn_v,
    input  logic [VPN_W-1:0]        key,
    output logic [N-1:0]            match,
    output logic                    any,
    output logic [IW-1:0]           idx
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = valid_v[i] && (vpn_v[i] == key);
    end

    assign any = |match;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/vxt_age.sv
module vxt_age #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 touch,
    input  logic [IW-1:0]        touch_idx,
    output logic [N-1:0][IW-1:0] age
);

    // Ages form a permutation: 0 is most recent, N-1 is oldest.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age[i] <= '0;
                else if (age[i] < age[touch_idx])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vxt_victim.sv
module vxt_victim #(
    parameter int N      = 16,
    parameter int LFSR_W = 8,
    localparam int IW    = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 use_lru,
    input  logic [N-1:0]         valid_v,
    input  logic [N-1:0]         wired_v,
    input  logic [N-1:0][IW-1:0] age,
    output logic                 vic_ok,
    output logic [IW-1:0]        vic_idx
);

    logic [LFSR_W-1:0] lfsr;
    logic [IW-1:0]     start;
    logic              free_ok, lru_ok, rnd_ok;
    logic [IW-1:0]     free_idx, lru_idx, rnd_idx, best;

    // Free-running maximal-length sequence (x^8+x^6+x^5+x^4+1)
    always_ff @(posedge clk) begin
        if (rst) lfsr <= LFSR_W'(1);
        else     lfsr <= {lfsr[LFSR_W-2:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    assign start = lfsr[IW-1:0] ^ lfsr[LFSR_W-1:LFSR_W-IW];

    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_v[i]) begin
                free_ok  = 1'b1;
                free_idx = IW'(i);
            end
        end

        lru_ok  = 1'b0;
        lru_idx = '0;
        best    = '0;
        for (int i = 0; i < N; i++) begin
            if (valid_v[i] && !wired_v[i] && (!lru_ok || age[i] > best)) begin
                lru_ok  = 1'b1;
                lru_idx = IW'(i);
                best    = age[i];
            end
        end

        rnd_ok  = 1'b0;
        rnd_idx = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(start) + k) % N;
            if (!rnd_ok && !wired_v[j]) begin
                rnd_ok  = 1'b1;
                rnd_idx = IW'(j);
            end
        end

        if (free_ok) begin
            vic_ok  = 1'b1;
            vic_idx = free_idx;
        end else if (use_lru) begin
            vic_ok  = lru_ok;
            vic_idx = lru_idx;
        end else begin
            vic_ok  = rnd_ok;
            vic_idx = rnd_idx;
        end
    end

endmodule

// File: rtl/vxt_tlb.sv
module vxt_tlb
    import vxt_pkg::*;
#(
    parameter int N      = 16,
    parameter int LFSR_W = 8,
    localparam int IW    = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             repl_lru,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_fault,
    input  logic             fl_req,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PFN_W-1:0] fl_pfn,
    input  logic [1:0]       fl_perm,
    input  logic             fl_wired,
    input  logic             flush
);

    entry_t [N-1:0]            tbl;
    logic   [N-1:0]            valid_v, wired_v;
    logic   [N-1:0][VPN_W-1:0] vpn_v;
    logic   [N-1:0]            lk_match, fm_match;
    logic                      lk_any, fm_any;
    logic   [IW-1:0]           lk_idx, fm_idx;
    logic   [N-1:0][IW-1:0]    age;
    logic                      vic_ok, wr_ok, touch;
    logic   [IW-1:0]           vic_idx, wr_idx, touch_idx;

    for (genvar i = 0; i < N; i++) begin : g_view
        assign valid_v[i] = tbl[i].valid;
        assign wired_v[i] = tbl[i].wired;
        assign vpn_v[i]   = tbl[i].vpn;
    end

    vxt_cam #(.N(N)) lk_cam_i (
        .valid_v (valid_v),
        .vpn_v   (vpn_v),
        .key     (lk_vpn),
        .match   (lk_match),
        .any     (lk_any),
        .idx     (lk_idx)
    );

    vxt_cam #(.N(N)) fl_cam_i (
        .valid_v (valid_v),
        .vpn_v   (vpn_v),
        .key     (fl_vpn),
        .match   (fm_match),
        .any     (fm_any),
        .idx     (fm_idx)
    );

    vxt_victim #(.N(N), .LFSR_W(LFSR_W)) vic_i (
        .clk     (clk),
        .rst     (rst),
        .use_lru (repl_lru),
        .valid_v (valid_v),
        .wired_v (wired_v),
        .age     (age),
        .vic_ok  (vic_ok),
        .vic_idx (vic_idx)
    );

    assign wr_ok  = fl_req && (fm_any || vic_ok);
    assign wr_idx = fm_any ? fm_idx : vic_idx;

    // An accepted fill owns the recency update of its cycle
    assign touch     = wr_ok || (lk_req && lk_any);
    assign touch_idx = wr_ok ? wr_idx : lk_idx;

    vxt_age #(.N(N)) age_i (
        .clk       (clk),
        .rst       (rst),
        .touch     (touch),
        .touch_idx (touch_idx),
        .age       (age)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (flush && !tbl[i].wired) tbl[i].valid <= 1'b0;
            end
            if (wr_ok) begin
                tbl[wr_idx] <= '{valid: 1'b1, wired: fl_wired, perm: perm_e'(fl_perm),
                                 vpn: fl_vpn, pfn: fl_pfn};
            end
        end
    end

    assign lk_hit   = lk_req && lk_any;
    assign lk_miss  = lk_req && !lk_any;
    assign lk_pfn   = lk_hit ? tbl[lk_idx].pfn : '0;
    assign lk_fault = lk_hit && !perm_allows(tbl[lk_idx].perm, acc_e'(lk_acc));

endmodule

// File: rtl/vxt_tlb_chk.sv
module vxt_tlb_chk
    import vxt_pkg::*;
#(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_req,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [PFN_W-1:0] lk_pfn,
    input logic             lk_fault,
    input logic             fl_req,
    input logic             flush,
    input logic [VPN_W-1:0] fl_vpn,
    input entry_t [N-1:0]   tbl,
    input logic [N-1:0]     lk_match,
    input logic [N-1:0]     fm_match,
    input logic             wr_ok,
    input logic [IW-1:0]    wr_idx
);

    p_hit_xor_miss_r2: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> (lk_hit ^ lk_miss));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_req |-> (!lk_hit && !lk_miss));

    p_pfn_zero_on_miss_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pfn == '0));

    p_fault_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> lk_hit);

    p_single_match_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match) && $onehot0(fm_match));

    p_fill_lands_r4: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> (tbl[$past(wr_idx)].valid && tbl[$past(wr_idx)].vpn == $past(fl_vpn)));

    p_no_wired_victim_r9: assert property (@(posedge clk) disable iff (rst)
        (fl_req && wr_ok && (fm_match == '0)) |-> !(tbl[wr_idx].valid && tbl[wr_idx].wired));

    for (genvar i = 0; i < N; i++) begin : g_ent
        p_flush_keeps_wired_r10: assert property (@(posedge clk) disable iff (rst)
            (flush && tbl[i].valid && tbl[i].wired) |=> tbl[i].valid);

        p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
            (flush && !tbl[i].wired && !(wr_ok && wr_idx == IW'(i))) |=> !tbl[i].valid);
    end

endmodule

bind vxt_tlb vxt_tlb_chk #(.N(N)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .lk_req   (lk_req),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .lk_pfn   (lk_pfn),
    .lk_fault (lk_fault),
    .fl_req   (fl_req),
    .flush    (flush),
    .fl_vpn   (fl_vpn),
    .tbl      (tbl),
    .lk_match (lk_match),
    .fm_match (fm_match),
    .wr_ok    (wr_ok),
    .wr_idx   (wr_idx)
);

// File: tb/vxt_tlb_tb.sv
module vxt_tlb_tb_top;

    localparam int CLK_P = 10;
    localparam int N     = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        repl_lru = 1'b1;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [19:0] lk_pfn;
    logic        fl_req = 1'b0;
    logic [19:0] fl_vpn = '0, fl_pfn = '0;
    logic [1:0]  fl_perm = '0;
    logic        fl_wired = 1'b0;
    logic        flush = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vxt_tlb dut_i (
        .clk(clk), .rst(rst), .repl_lru(repl_lru),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_fault(lk_fault),
        .fl_req(fl_req), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_perm(fl_perm),
        .fl_wired(fl_wired), .flush(flush)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural model: per-slot contents and time of last use
    bit          m_valid[N], m_wired[N];
    logic [19:0] m_vpn[N], m_pfn[N];
    logic [1:0]  m_perm[N];
    longint      m_last[N];
    longint      tnow;
    bit          pend;
    logic [19:0] p_vpn, p_pfn;
    logic [1:0]  p_perm;
    bit          p_wired;
    longint      p_time;

    function automatic bit allowed(logic [1:0] perm, logic [1:0] acc);
        if (perm == 2'd0) return acc == 2'd0;
        if (perm == 2'd1) return acc == 2'd0 || acc == 2'd1;
        if (perm == 2'd2) return acc == 2'd2;
        return 0;
    endfunction

    function automatic int m_find(logic [19:0] v);
        for (int j = 0; j < N; j++) if (m_valid[j] && m_vpn[j] == v) return j;
        return -1;
    endfunction

    task automatic m_reset();
        for (int j = 0; j < N; j++) begin
            m_valid[j] = 0; m_wired[j] = 0; m_last[j] = -j;
        end
        tnow = 1;
        pend = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        m_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fail_chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_cycle(bit lr, logic [19:0] lv, logic [1:0] la,
                            bit fr, logic [19:0] fv, logic [19:0] fp, logic [1:0] fpm, bit fw,
                            bit fl, string req);
        int hj, tgt;
        bit pnow;
        lk_req = lr; lk_vpn = lv; lk_acc = la;
        fl_req = fr; fl_vpn = fv; fl_pfn = fp; fl_perm = fpm; fl_wired = fw;
        flush = fl;
        #1;
        hj = m_find(lv);
        if (lr) begin
            logic [19:0] ep;
            bit ef;
            ep = (hj >= 0) ? m_pfn[hj] : 20'd0;
            ef = (hj >= 0) && !allowed(m_perm[hj], la);
            fail_chk(lk_hit == (hj >= 0) && lk_miss == (hj < 0) && lk_pfn == ep && lk_fault == ef,
                     req, "hit/miss/pfn/fault",
                     {lk_hit, lk_miss, lk_fault, lk_pfn}, {hj >= 0, hj < 0, ef, ep});
        end else begin
            fail_chk(!lk_hit && !lk_miss, req, "idle hit/miss", {lk_hit, lk_miss}, 0);
        end
        @(posedge clk);
        tgt = -1;
        pnow = 0;
        if (fr) begin
            tgt = m_find(fv);
            if (tgt < 0) for (int j = N - 1; j >= 0; j--) if (!m_valid[j]) tgt = j;
            if (tgt < 0 && repl_lru) begin
                for (int j = 0; j < N; j++)
                    if (m_valid[j] && !m_wired[j] && (tgt < 0 || m_last[j] < m_last[tgt])) tgt = j;
            end else if (tgt < 0) begin
                for (int j = 0; j < N; j++) if (!m_wired[j]) pnow = 1;
            end
        end
        if (tgt >= 0) m_last[tgt] = tnow;
        else if (!pnow && lr && hj >= 0) m_last[hj] = tnow;
        if (fl) for (int j = 0; j < N; j++) if (!m_wired[j]) m_valid[j] = 0;
        if (tgt >= 0) begin
            m_valid[tgt] = 1; m_wired[tgt] = fw; m_vpn[tgt] = fv;
            m_pfn[tgt] = fp; m_perm[tgt] = fpm;
        end
        if (pnow) begin
            pend = 1; p_vpn = fv; p_pfn = fp; p_perm = fpm; p_wired = fw; p_time = tnow;
        end
        tnow++;
        @(negedge clk);
        lk_req = 0; fl_req = 0; flush = 0;
    endtask

    task automatic look(logic [19:0] v, logic [1:0] a, string req);
        do_cycle(1, v, a, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic fill(logic [19:0] v, logic [19:0] p, logic [1:0] pm, bit w, string req);
        do_cycle(0, 0, 0, 1, v, p, pm, w, 0, req);
    endtask

    task automatic probe_all(logic [1:0] base, string req);
        logic [19:0] vs[N];
        bit          ok[N];
        for (int j = 0; j < N; j++) begin ok[j] = m_valid[j]; vs[j] = m_vpn[j]; end
        for (int j = 0; j < N; j++)
            if (ok[j]) look(vs[j], 2'((j + base) % 4), req);
        look(20'hFFFFF, 2'd0, req);
    endtask

    // random eviction: find which unpinned slot disappeared
    task automatic resolve(string req);
        int misses, vic;
        misses = 0; vic = -1;
        for (int j = 0; j < N; j++) begin
            lk_req = 1; lk_vpn = m_vpn[j]; lk_acc = 0;
            #1;
            if (!lk_hit) begin misses++; vic = j; end
            else fail_chk(lk_pfn == m_pfn[j], req, "survivor pfn", lk_pfn, m_pfn[j]);
            @(posedge clk);
            if (lk_hit) m_last[j] = tnow;
            tnow++;
            @(negedge clk);
        end
        lk_req = 0;
        fail_chk(misses == 1, req, "evicted count", misses, 1);
        if (vic >= 0) begin
            fail_chk(!m_wired[vic], req, "victim pinned", m_wired[vic], 0);
            m_vpn[vic] = p_vpn; m_pfn[vic] = p_pfn; m_perm[vic] = p_perm;
            m_wired[vic] = p_wired; m_last[vic] = p_time; m_valid[vic] = 1;
        end
        pend = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        @(negedge clk);
        do_reset();

        // R1: empty after reset
        look(20'h00000, 2'd0, "R1");
        look(20'h12345, 2'd1, "R1");
        do_cycle(0, 20'h12345, 0, 0, 0, 0, 0, 0, 0, "R2");

        // R4/R6: fill all slots, some pinned, all permission codes
        repl_lru = 1;
        for (int k = 0; k < N; k++)
            fill(20'h100 + 20'(k), 20'h5000 + 20'(k), 2'(k % 4), (k == 2 || k == 5), "R6");
        probe_all(0, "R4");
        probe_all(1, "R3");
        probe_all(2, "R3");
        probe_all(3, "R3");

        // R5: overwrite in place, nothing evicted
        fill(20'h103, 20'hAAAAA, 2'd1, 0, "R5");
        probe_all(0, "R5");

        // R7/R9: LRU evictions skipping pinned old entries
        look(20'h100, 2'd0, "R7");
        look(20'h106, 2'd0, "R7");
        for (int k = 0; k < 5; k++) begin
            fill(20'h200 + 20'(k), 20'h6000 + 20'(k), 2'd1, 0, "R7");
            probe_all(2'(k), "R7");
        end
        look(20'h102, 2'd0, "R9");

        // R11: lookup and fill in one cycle
        do_cycle(1, 20'h300, 2'd0, 1, 20'h300, 20'h7300, 2'd0, 0, 0, "R11");
        look(20'h300, 2'd0, "R11");
        do_cycle(1, 20'h105, 2'd0, 1, 20'h301, 20'h7301, 2'd2, 0, 0, "R11");
        fill(20'h302, 20'h7302, 2'd0, 0, "R11");
        probe_all(0, "R11");

        // R10: flush keeps pinned entries; R11 flush with fill
        do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        probe_all(1, "R10");
        fill(20'h400, 20'h8400, 2'd1, 0, "R6");
        do_cycle(0, 0, 0, 1, 20'h401, 20'h8401, 2'd0, 0, 1, "R11");
        probe_all(0, "R11");

        // R9: fully pinned table drops a new fill
        for (int k = 0; k < 14; k++)
            fill(20'h500 + 20'(k), 20'h9500 + 20'(k), 2'd0, 1, "R9");
        fill(20'h777, 20'h12345, 2'd0, 0, "R9");
        probe_all(0, "R9");
        look(20'h777, 2'd0, "R9");
        do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        probe_all(0, "R10");

        // R8: random eviction
        do_reset();
        look(20'h100, 2'd0, "R1");
        repl_lru = 0;
        for (int k = 0; k < N; k++)
            fill(20'hA00 + 20'(k), 20'hB000 + 20'(k), 2'd1, (k % 5 == 0), "R8");
        for (int k = 0; k < 6; k++) begin
            fill(20'hC00 + 20'(k), 20'hD000 + 20'(k), 2'd1, 0, "R8");
            if (pend) resolve("R8");
            else fail_chk(0, "R8", "random fill not pending", 0, 1);
            look(20'hC00 + 20'(k), 2'd0, "R8");
        end
        probe_all(0, "R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule